// File: doc/BRIEF.md
# Private Cache Controller with Shared Bypass

This block sits between a processor core's load/store port and a network request port. Accesses to private addresses are held in a set-associative cache. The cache writes back modified lines and picks its victim in the order the lines were filled. A miss fetches a whole line. When the chosen victim holds modified data, the same network request also carries that line back to memory.

Addresses inside a configurable shared window are never cached. Each one goes to the network as a single read or write that keeps its byte, half-word or word size. The core raises a request with an opcode, an address and store data. It then receives exactly one response pulse. A hit answers in the cycle after acceptance. A miss, a shared access or a write-no-allocate store holds off further requests until the network answers.

Way count, total size, line size, shared window bounds and the write-miss allocation choice are parameters. With one way the cache is direct-mapped, and with one set it is fully associative. The default is write-allocate.

Top module: `pcache_ctrl`

## Requirements
- R1: After reset, `core_req_ready` is 1, `core_rsp_full` is 0 and `net_req_valid` is 0. Every line is invalid, so the first access to any private line goes to the network.
- R2: A private load miss sends one network read with `net_req_size` = 3 (full line) at the line-aligned address. The line is placed in the cache, and the requested datum comes back on the core response.
- R3: An access that hits raises `core_rsp_full` in the cycle right after acceptance and sends no network request.
- R4: Opcode bit 2 selects a store (1) or a load (0). Bits 1:0 give the size: 0 byte, 1 half-word, 2 word. Bytes are little-endian, placed by address bits 1:0. Load data is right-aligned and zero-extended.
- R5: A store hit is written into the cached line only and sends nothing to the network. The line becomes modified.
- R6: On a private miss, the victim is the way in the set that was filled earliest, no matter which lines hit since.
- R7: When the victim is valid and modified, the miss request sets `net_req_evict` and puts the victim's base address in `net_req_evict_addr`. It carries the victim line, with all stores merged, in `net_req_data`. A clean victim leaves `net_req_evict` at 0.
- R8: Every access inside the shared window becomes its own network request, including a repeat of the same access. The request has the exact address, the access size in `net_req_size` and the store value right-aligned in `net_req_data[31:0]`. A load takes its word from `net_rsp_data[31:0]`.
- R9: From the acceptance of an access that needs the network until its response, `core_req_ready` stays 0. A waiting network request holds its fields steady.
- R10: With write-allocate (the default), a store miss fetches the line as in R2 and merges the store into it. Later loads to that line hit.
- R11: Each accepted request gets one response whose `core_rsp_op` equals the request opcode. Store responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_full | input | 1 | Core request present |
| core_req_op | input | 3 | Request opcode: store flag and size |
| core_req_addr | input | 32 | Byte address |
| core_req_data | input | 32 | Store value, right-aligned |
| core_req_ready | output | 1 | Request accepted on this edge when high |
| core_rsp_full | output | 1 | One-cycle response pulse |
| core_rsp_op | output | 3 | Opcode of the answered request |
| core_rsp_data | output | 32 | Load result, zero for stores |
| net_req_valid | output | 1 | Network request pending |
| net_req_ready | input | 1 | Network takes the request |
| net_req_write | output | 1 | Single write (1) or read (0) |
| net_req_size | output | 2 | 0 byte, 1 half, 2 word, 3 line |
| net_req_addr | output | 32 | Access or line address |
| net_req_data | output | LINE_BYTES*8 | Victim line or store value |
| net_req_evict | output | 1 | Victim line travels with the request |
| net_req_evict_addr | output | 32 | Base address of the victim line |
| net_rsp_valid | input | 1 | Network answer present |
| net_rsp_data | input | LINE_BYTES*8 | Filled line or shared word |

## Verification
The assertions take it that the network raises `net_rsp_valid` once per request, and only after that request has been taken. They also take it that the core holds a request until `core_req_ready` is seen high, and that the shared window does not overlap the private lines being exercised. The bench's network model answers each request exactly once after a fixed delay, and nothing else drives the response. The core is driven only through a task that issues one access and waits for its response before the next, so neither side breaks these assumptions.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_NETREQ  = 2'd1,
        ST_NETWAIT = 2'd2
    } ctrl_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_LINE = 2'd3;

endpackage

// File: rtl/pcache_way_match.sv
module pcache_way_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 27,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic [WAYS-1:0]            match_o,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_o[w]) way_o = WAY_W'(w);
        end
    end

    assign hit_o = |match_o;

endmodule

// File: rtl/pcache_lane.sv
module pcache_lane #(
    parameter int LINE_BYTES = 8,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [LINE_BITS-1:0] line_i,
    input  logic [OFF_W-1:0]     off_i,
    input  logic [1:0]           size_i,
    input  logic [31:0]          wdata_i,
    output logic [LINE_BITS-1:0] line_o,
    output logic [31:0]          rdata_o
);

    logic [LINE_BITS-1:0] shifted;
    logic [31:0]          word, wlane, mask, merged, moved;
    logic [3:0]           be;
    int unsigned          wsh;

    always_comb begin
        wsh     = 32'(off_i >> 2) * 32;
        shifted = line_i >> wsh;
        word    = shifted[31:0];
        moved   = word >> {off_i[1:0], 3'b000};
        unique case (size_i)
            2'd0: begin
                be      = 4'b0001 << off_i[1:0];
                wlane   = {4{wdata_i[7:0]}};
                rdata_o = {24'h0, moved[7:0]};
            end
            2'd1: begin
                be      = 4'b0011 << {off_i[1], 1'b0};
                wlane   = {2{wdata_i[15:0]}};
                rdata_o = {16'h0, moved[15:0]};
            end
            default: begin
                be      = 4'b1111;
                wlane   = wdata_i;
                rdata_o = word;
            end
        endcase
        mask   = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        merged = (word & ~mask) | (wlane & mask);
        line_o = (line_i & ~(LINE_BITS'(mask) << wsh)) | (LINE_BITS'(merged & mask) << wsh);
    end

endmodule

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
    import pcache_pkg::*;
#(
    parameter int          WAYS        = 8,
    parameter int          TOTAL_BYTES = 256,
    parameter int          LINE_BYTES  = 8,
    parameter bit          WRITE_ALLOC = 1'b1,
    parameter logic [31:0] SHARED_BASE = 32'h8000_0000,
    parameter logic [31:0] SHARED_LAST = 32'h8000_FFFF,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 core_req_full,
    input  logic [2:0]           core_req_op,
    input  logic [31:0]          core_req_addr,
    input  logic [31:0]          core_req_data,
    output logic                 core_req_ready,
    output logic                 core_rsp_full,
    output logic [2:0]           core_rsp_op,
    output logic [31:0]          core_rsp_data,
    output logic                 net_req_valid,
    input  logic                 net_req_ready,
    output logic                 net_req_write,
    output logic [1:0]           net_req_size,
    output logic [31:0]          net_req_addr,
    output logic [LINE_BITS-1:0] net_req_data,
    output logic                 net_req_evict,
    output logic [31:0]          net_req_evict_addr,
    input  logic                 net_rsp_valid,
    input  logic [LINE_BITS-1:0] net_rsp_data
);

    localparam int LINES    = TOTAL_BYTES / LINE_BYTES;
    localparam int SETS     = LINES / WAYS;
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int SET_BITS = $clog2(SETS);
    localparam int IDX_W    = (SET_BITS > 0) ? SET_BITS : 1;
    localparam int TAG_W    = 32 - OFF_W - SET_BITS;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LI_W     = (LINES > 1) ? $clog2(LINES) : 1;

    typedef struct packed {
        ctrl_state_e                      st;
        logic [LINES-1:0]                 valid;
        logic [LINES-1:0]                 dirty;
        logic [LINES-1:0][TAG_W-1:0]      tag;
        logic [LINES-1:0][LINE_BITS-1:0]  data;
        logic [SETS-1:0][WAY_W-1:0]       fifo;
        logic [2:0]                       p_op;
        logic [31:0]                      p_addr;
        logic [31:0]                      p_wdata;
        logic [WAY_W-1:0]                 p_way;
        logic                             p_line;
        logic                             n_write;
        logic [1:0]                       n_size;
        logic [31:0]                      n_addr;
        logic [LINE_BITS-1:0]             n_data;
        logic                             n_evict;
        logic [31:0]                      n_eaddr;
        logic                             r_full;
        logic [2:0]                       r_op;
        logic [31:0]                      r_data;
    } regs_t;

    regs_t q, d;

    function automatic logic in_window(input logic [31:0] a);
        return (a >= SHARED_BASE) && (a <= SHARED_LAST);
    endfunction

    // Address split for the incoming request and the pending one
    logic [IDX_W-1:0] idx, p_idx;
    logic [TAG_W-1:0] tag, p_tag;
    assign idx   = IDX_W'((core_req_addr >> OFF_W) & 32'(SETS - 1));
    assign tag   = TAG_W'(core_req_addr >> (OFF_W + SET_BITS));
    assign p_idx = IDX_W'((q.p_addr >> OFF_W) & 32'(SETS - 1));
    assign p_tag = TAG_W'(q.p_addr >> (OFF_W + SET_BITS));

    // Gather the addressed set
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w] = q.valid[int'(idx) * WAYS + w];
            set_tags[w]  = q.tag[int'(idx) * WAYS + w];
        end
    end

    logic [WAYS-1:0]  hit_vec;
    logic             hit;
    logic [WAY_W-1:0] hit_way;

    pcache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
        .valid_i (set_valid),
        .tags_i  (set_tags),
        .tag_i   (tag),
        .match_o (hit_vec),
        .hit_o   (hit),
        .way_o   (hit_way)
    );

    logic [LI_W-1:0]  hl, vl, pl;
    logic [WAY_W-1:0] vway;
    assign hl   = LI_W'(int'(idx) * WAYS + int'(hit_way));
    assign vway = q.fifo[idx];
    assign vl   = LI_W'(int'(idx) * WAYS + int'(vway));
    assign pl   = LI_W'(int'(p_idx) * WAYS + int'(q.p_way));

    // Lane unit on the hit path
    logic [LINE_BITS-1:0] hit_line_new;
    logic [31:0]          hit_rdata;
    pcache_lane #(.LINE_BYTES(LINE_BYTES)) i_lane_hit (
        .line_i  (q.data[hl]),
        .off_i   (core_req_addr[OFF_W-1:0]),
        .size_i  (core_req_op[1:0]),
        .wdata_i (core_req_data),
        .line_o  (hit_line_new),
        .rdata_o (hit_rdata)
    );

    // Lane unit on the network return path
    logic [LINE_BITS-1:0] ret_line_in, ret_line_new;
    logic [OFF_W-1:0]     ret_off;
    logic [31:0]          ret_rdata;
    assign ret_line_in = q.p_line ? net_rsp_data : LINE_BITS'(net_rsp_data[31:0]);
    assign ret_off     = q.p_line ? q.p_addr[OFF_W-1:0] : OFF_W'(q.p_addr[1:0]);

    pcache_lane #(.LINE_BYTES(LINE_BYTES)) i_lane_ret (
        .line_i  (ret_line_in),
        .off_i   (ret_off),
        .size_i  (q.p_op[1:0]),
        .wdata_i (q.p_wdata),
        .line_o  (ret_line_new),
        .rdata_o (ret_rdata)
    );

    logic       is_store, bypass;
    logic [1:0] size_n;
    assign is_store = core_req_op[2];
    assign size_n   = (core_req_op[1:0] == SZ_LINE) ? SZ_WORD : core_req_op[1:0];
    assign bypass   = in_window(core_req_addr) || (!hit && is_store && !WRITE_ALLOC);

    always_comb begin
        d        = q;
        d.r_full = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (core_req_full) begin
                    d.p_op    = core_req_op;
                    d.p_addr  = core_req_addr;
                    d.p_wdata = core_req_data;
                    if (bypass) begin
                        d.p_line  = 1'b0;
                        d.n_write = is_store;
                        d.n_size  = size_n;
                        d.n_addr  = core_req_addr;
                        d.n_data  = LINE_BITS'(core_req_data);
                        d.n_evict = 1'b0;
                        d.n_eaddr = '0;
                        d.st      = ST_NETREQ;
                    end else if (hit) begin
                        if (is_store) begin
                            d.data[hl]  = hit_line_new;
                            d.dirty[hl] = 1'b1;
                        end
                        d.r_full = 1'b1;
                        d.r_op   = core_req_op;
                        d.r_data = is_store ? 32'h0 : hit_rdata;
                    end else begin
                        d.p_line  = 1'b1;
                        d.p_way   = vway;
                        d.n_write = 1'b0;
                        d.n_size  = SZ_LINE;
                        d.n_addr  = core_req_addr & ~32'(LINE_BYTES - 1);
                        d.n_evict = q.valid[vl] && q.dirty[vl];
                        d.n_eaddr = (32'(q.tag[vl]) << (OFF_W + SET_BITS)) | (32'(idx) << OFF_W);
                        d.n_data  = q.data[vl];
                        d.st      = ST_NETREQ;
                    end
                end
            end
            ST_NETREQ: begin
                if (net_req_ready) d.st = ST_NETWAIT;
            end
            ST_NETWAIT: begin
                if (net_rsp_valid) begin
                    if (q.p_line) begin
                        d.data[pl]   = q.p_op[2] ? ret_line_new : net_rsp_data;
                        d.valid[pl]  = 1'b1;
                        d.dirty[pl]  = q.p_op[2];
                        d.tag[pl]    = p_tag;
                        d.fifo[p_idx] = (q.fifo[p_idx] == WAY_W'(WAYS - 1)) ? '0 : q.fifo[p_idx] + 1'b1;
                    end
                    d.r_full = 1'b1;
                    d.r_op   = q.p_op;
                    d.r_data = q.p_op[2] ? 32'h0 : ret_rdata;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign core_req_ready     = (q.st == ST_IDLE);
    assign core_rsp_full      = q.r_full;
    assign core_rsp_op        = q.r_op;
    assign core_rsp_data      = q.r_data;
    assign net_req_valid      = (q.st == ST_NETREQ);
    assign net_req_write      = q.n_write;
    assign net_req_size       = q.n_size;
    assign net_req_addr       = q.n_addr;
    assign net_req_data       = q.n_data;
    assign net_req_evict      = q.n_evict;
    assign net_req_evict_addr = q.n_eaddr;

    // Line fetches are aligned to the line
    assert_line_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (net_req_valid && net_req_size == SZ_LINE) |-> ((net_req_addr & 32'(LINE_BYTES - 1)) == 32'h0));

    // At most one way matches in a set
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // Eviction rides only on a line fetch, for a different line
    assert_evict_with_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (net_req_valid && net_req_evict) |-> (net_req_size == SZ_LINE && net_req_evict_addr != net_req_addr));

    // Shared addresses never produce a line transfer
    assert_shared_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (net_req_valid && in_window(net_req_addr)) |-> (net_req_size != SZ_LINE));

    // A shared access closes the core port on the next cycle
    assert_shared_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_full && core_req_ready && in_window(core_req_addr)) |=> !core_req_ready);

    // A waiting network request holds
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (net_req_valid && !net_req_ready) |=> (net_req_valid && $stable(net_req_addr) && $stable(net_req_size)));

    // A response follows an acceptance or a network answer
    assert_rsp_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_rsp_full |-> ($past(core_req_full && core_req_ready) || $past(net_rsp_valid)));

endmodule

// File: tb/test_pcache_ctrl.sv
module test_pcache_ctrl;

    localparam int LB   = 8;
    localparam int LBIT = LB * 8;
    localparam int LAT  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            core_req_full = 1'b0;
    logic [2:0]      core_req_op = '0;
    logic [31:0]     core_req_addr = '0;
    logic [31:0]     core_req_data = '0;
    logic            core_req_ready, core_rsp_full;
    logic [2:0]      core_rsp_op;
    logic [31:0]     core_rsp_data;
    logic            net_req_valid, net_req_write, net_req_evict;
    logic            net_req_ready = 1'b1;
    logic [1:0]      net_req_size;
    logic [31:0]     net_req_addr, net_req_evict_addr;
    logic [LBIT-1:0] net_req_data;
    logic            net_rsp_valid = 1'b0;
    logic [LBIT-1:0] net_rsp_data = '0;

    always #5 clk = ~clk;

    pcache_ctrl #(.LINE_BYTES(LB)) i_pcache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .core_req_full(core_req_full), .core_req_op(core_req_op),
        .core_req_addr(core_req_addr), .core_req_data(core_req_data),
        .core_req_ready(core_req_ready), .core_rsp_full(core_rsp_full),
        .core_rsp_op(core_rsp_op), .core_rsp_data(core_rsp_data),
        .net_req_valid(net_req_valid), .net_req_ready(net_req_ready),
        .net_req_write(net_req_write), .net_req_size(net_req_size),
        .net_req_addr(net_req_addr), .net_req_data(net_req_data),
        .net_req_evict(net_req_evict), .net_req_evict_addr(net_req_evict_addr),
        .net_rsp_valid(net_rsp_valid), .net_rsp_data(net_rsp_data)
    );

    int checks = 0;
    int fails  = 0;
    int net_cnt = 0;

    logic [31:0] bmem [512];
    logic [31:0] rmem [512];

    logic            lq_write, lq_evict;
    logic [1:0]      lq_size;
    logic [31:0]     lq_addr, lq_eaddr;
    logic [LBIT-1:0] lq_data;

    function automatic int widx(input logic [31:0] a);
        return int'({a[31], a[9:2]});
    endfunction

    function automatic logic [31:0] put(input logic [31:0] old, input logic [1:0] sz,
                                        input logic [1:0] off, input logic [31:0] v);
        logic [31:0] m;
        m = (sz == 2'd0) ? (32'hFF << (8 * off)) :
            (sz == 2'd1) ? (32'hFFFF << (16 * off[1])) : 32'hFFFF_FFFF;
        return (old & ~m) | ((v << (8 * ((sz == 2'd2) ? 2'd0 : off))) & m);
    endfunction

    function automatic logic [31:0] get(input logic [31:0] w, input logic [1:0] sz,
                                        input logic [1:0] off);
        logic [31:0] s;
        s = w >> (8 * off);
        return (sz == 2'd0) ? {24'h0, s[7:0]} : (sz == 2'd1) ? {16'h0, s[15:0]} : w;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Network memory model: one answer per request after LAT cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && net_req_valid) begin
                logic [LBIT-1:0] ans;
                net_cnt++;
                lq_write = net_req_write; lq_evict = net_req_evict; lq_size = net_req_size;
                lq_addr = net_req_addr; lq_eaddr = net_req_evict_addr; lq_data = net_req_data;
                ans = '0;
                if (net_req_size == 2'd3) begin
                    if (net_req_evict)
                        for (int k = 0; k < LB / 4; k++)
                            bmem[widx(net_req_evict_addr + 32'(4 * k))] = net_req_data[32 * k +: 32];
                    for (int k = 0; k < LB / 4; k++)
                        ans[32 * k +: 32] = bmem[widx(net_req_addr + 32'(4 * k))];
                end else if (net_req_write) begin
                    bmem[widx(net_req_addr)] = put(bmem[widx(net_req_addr)], net_req_size,
                                                   net_req_addr[1:0], net_req_data[31:0]);
                end else begin
                    ans[31:0] = bmem[widx(net_req_addr)];
                end
                repeat (LAT - 1) @(negedge clk);
                net_rsp_valid = 1'b1;
                net_rsp_data  = ans;
                @(negedge clk);
                net_rsp_valid = 1'b0;
            end
        end
    end

    task automatic access(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat, output int nets, output bit bp_bad);
        int n0;
        n0 = net_cnt;
        bp_bad = 1'b0;
        @(negedge clk);
        core_req_full = 1'b1; core_req_op = op; core_req_addr = addr; core_req_data = wd;
        while (!core_req_ready) @(negedge clk);
        @(negedge clk);
        core_req_full = 1'b0;
        lat = 1;
        while (!core_rsp_full) begin
            if (core_req_ready) bp_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        rd = core_rsp_data;
        chk("R11", 64'(core_rsp_op), 64'(op), "response opcode echo");
        if (op[2]) begin
            chk("R11", 64'(rd), 64'h0, "store response data");
            rmem[widx(addr)] = put(rmem[widx(addr)], op[1:0], addr[1:0], wd);
        end
        nets = net_cnt - n0;
    endtask

    // Load helper comparing against the reference image
    task automatic load_chk(input string req, input logic [31:0] addr, input int exp_nets,
                            input string what);
        logic [31:0] rd; int lat, nets; bit bp;
        logic [31:0] exp;
        exp = rmem[widx(addr)];
        access(3'b010, addr, 32'h0, rd, lat, nets, bp);
        chk(req, 64'(rd), 64'(exp), {what, " data"});
        chk(req, 64'(nets), 64'(exp_nets), {what, " network requests"});
    endtask

    // op[71:68]=requirement no, [67:65]=opcode, [64:33]=address, [32:1]=store data, [0]=network expected
    localparam int NV = 17;
    localparam logic [71:0] VEC [NV] = '{
        {4'd2,  3'b010, 32'h0000_0040, 32'h0,          1'b1}, // R2 load miss
        {4'd3,  3'b010, 32'h0000_0044, 32'h0,          1'b0}, // R3 hit
        {4'd5,  3'b100, 32'h0000_0041, 32'h0000_00AB,  1'b0}, // R5 byte store hit
        {4'd4,  3'b101, 32'h0000_0046, 32'h0000_1234,  1'b0}, // R4 half store
        {4'd4,  3'b010, 32'h0000_0040, 32'h0,          1'b0}, // R4 merged word
        {4'd4,  3'b001, 32'h0000_0046, 32'h0,          1'b0}, // R4 half load
        {4'd4,  3'b000, 32'h0000_0041, 32'h0,          1'b0}, // R4 byte load
        {4'd10, 3'b110, 32'h0000_0068, 32'hDEAD_BEEF,  1'b1}, // R10 store miss allocates
        {4'd10, 3'b010, 32'h0000_006C, 32'h0,          1'b0}, // R10 neighbour hits
        {4'd10, 3'b010, 32'h0000_0068, 32'h0,          1'b0}, // R10 merged value
        {4'd8,  3'b010, 32'h8000_0010, 32'h0,          1'b1}, // R8 shared load
        {4'd8,  3'b010, 32'h8000_0010, 32'h0,          1'b1}, // R8 repeat not cached
        {4'd8,  3'b100, 32'h8000_0013, 32'h0000_0077,  1'b1}, // R8 shared byte store
        {4'd8,  3'b000, 32'h8000_0013, 32'h0,          1'b1}, // R8 shared byte load
        {4'd8,  3'b101, 32'h8000_0022, 32'h0000_BEEF,  1'b1}, // R8 shared half store
        {4'd8,  3'b010, 32'h8000_0020, 32'h0,          1'b1}, // R8 shared word load
        {4'd8,  3'b001, 32'h8000_0022, 32'h0,          1'b1}  // R8 shared half load
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            bmem[i] = 32'h3C00_0000 ^ (32'(i) * 32'h0101_0107);
            rmem[i] = bmem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 64'(core_req_ready), 64'd1, "ready after reset");
        chk("R1", 64'(core_rsp_full), 64'd0, "no response after reset");
        chk("R1", 64'(net_req_valid), 64'd0, "no network request after reset");

        for (int v = 0; v < NV; v++) begin
            logic [2:0]  op;
            logic [31:0] addr, wd, rd, exp;
            int lat, nets; bit bp;
            string tag;
            op = VEC[v][67:65]; addr = VEC[v][64:33]; wd = VEC[v][32:1];
            tag = $sformatf("R%0d", VEC[v][71:68]);
            exp = get(rmem[widx(addr)], op[1:0], addr[1:0]);
            access(op, addr, wd, rd, lat, nets, bp);
            if (!op[2]) chk(tag, 64'(rd), 64'(exp), $sformatf("vector %0d load data", v));
            chk(tag, 64'(nets), 64'(VEC[v][0]), $sformatf("vector %0d network requests", v));
            if (nets == 0) chk("R3", 64'(lat), 64'd1, $sformatf("vector %0d hit latency", v));
            else begin
                chk("R9", 64'(bp), 64'd0, $sformatf("vector %0d ready during wait", v));
                if (addr[31]) begin
                    chk("R8", 64'(lq_size), 64'(op[1:0]), "shared size kept");
                    chk("R8", 64'(lq_addr), 64'(addr), "shared exact address");
                    chk("R8", 64'(lq_write), 64'(op[2]), "shared direction");
                end else begin
                    chk("R2", 64'(lq_size), 64'd3, "line size on miss");
                    chk("R2", 64'(lq_addr), 64'(addr & ~32'(LB - 1)), "line-aligned miss address");
                    chk("R2", 64'(lq_write), 64'd0, "miss is a read");
                    chk("R7", 64'(lq_evict), 64'd0, "empty victim not evicted");
                end
            end
        end

        // Fill the rest of set 0; line 0x040 (modified) sits in the oldest way
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a;
            a = 32'(k * 32);
            if (a != 32'h40) begin
                load_chk("R6", a, 1, "set fill");
                chk("R7", 64'(lq_evict), 64'd0, "fill into invalid way");
            end
        end
        load_chk("R6", 32'h040, 0, "oldest line still resident");
        load_chk("R6", 32'h100, 1, "ninth line replaces oldest");
        chk("R7", 64'(lq_evict), 64'd1, "modified victim evicted");
        chk("R7", 64'(lq_eaddr), 64'h40, "victim base address");
        chk("R7", 64'(lq_data[31:0]), 64'(rmem[widx(32'h40)]), "victim word 0");
        chk("R7", 64'(lq_data[63:32]), 64'(rmem[widx(32'h44)]), "victim word 1");
        load_chk("R6", 32'h000, 0, "second-filled line survives");
        load_chk("R6", 32'h120, 1, "next victim");
        chk("R7", 64'(lq_evict), 64'd0, "clean victim not evicted");
        chk("R6", 64'(lq_addr), 64'h120, "fetch of new line");
        load_chk("R6", 32'h020, 0, "third-filled line survives");
        load_chk("R6", 32'h000, 1, "replaced line misses");
        load_chk("R7", 32'h044, 1, "written-back line returns with stores");

        // Reset in the middle of a warm cache
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 64'(core_req_ready), 64'd1, "ready after second reset");
        chk("R1", 64'(net_req_valid), 64'd0, "idle network after second reset");
        load_chk("R1", 32'h100, 1, "lines invalid after reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule